// File: doc/BRIEF.md
# DMA Page-Register Address Generator

This block keeps the page bytes of a four-channel DMA controller and turns them into a full physical transfer address. Every channel has a low page byte and a high page byte. Software reaches them through a byte port. The three low bits of the port number pick a channel through a fixed, sparse map, and a select line picks the low or the high byte.

When the transfer engine issues a request, it supplies the channel, that channel's base address and base count, the direction bit and a transfer offset and length. One cycle later the block returns the 31-bit physical start address and the transfer size in bytes. Two parameters fix the controller flavour:

- **Byte or word controller.** On the word-wide controller, addresses and sizes count in 16-bit units, so both are shifted left by one.
- **High page register.** A flag decides whether the high page register exists.

Top module: `dma_page_addr_gen`

## Requirements
- R1: Port numbers 7, 3, 1 and 2 (low three bits) reach the page bytes of channels 0, 1, 2 and 3 respectively. With `pg_hi`=0 a write stores `pg_wdata` in that channel's low page on the clock edge, and `pg_rdata` shows the stored byte combinationally.
- R2: Port numbers 0, 4, 5 and 6 map to no channel. Writes to them change no page byte, and `pg_rdata` is 0 while one of them is selected.
- R3: With the high page enabled (`HPAGE_EN`=1), `pg_hi`=1 reaches a separate 8-bit high page byte per channel. It is written and read like the low page and does not disturb it.
- R4: With `HPAGE_EN`=0, high page reads return 0, high page writes are ignored, and the high page adds nothing to the address.
- R5: The physical base is the high page bits 6:0 at bit 24, the low page at bit 16 and the current address in the low bits, combined by OR. High page bit 7 never reaches the address.
- R6: With `req_dec`=0 the output address is physical base plus offset, modulo 2^31.
- R7: With `req_dec`=1 the output address is physical base minus offset minus length, modulo 2^31.
- R8: With `WIDE16`=1 the current address is the base address shifted left by one bit, so bit 15 of the base lands on bit 16.
- R9: `out_size` is the base count plus one, shifted left by one when `WIDE16`=1.
- R10: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high, with `out_addr` and `out_size` computed from that request. Without a request, `out_addr` and `out_size` hold their values.
- R11: After reset all page bytes read 0, `out_valid` is 0 and `out_addr` and `out_size` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_wr | input | 1 | Page byte write strobe |
| pg_hi | input | 1 | 1 selects the high page byte, 0 the low page byte |
| pg_port | input | 3 | Low bits of the page port number |
| pg_wdata | input | 8 | Page write data |
| pg_rdata | output | 8 | Page read data (combinational) |
| req_valid | input | 1 | Address request strobe |
| req_chan | input | 2 | Requesting channel |
| req_base | input | 16 | Channel base address |
| req_count | input | 16 | Channel base count |
| req_dec | input | 1 | 1 for decrementing transfers |
| req_offset | input | OFS_W | Position within the transfer |
| req_len | input | OFS_W | Length of the access |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_addr | output | 31 | Physical start address |
| out_size | output | 18 | Transfer size |

## Verification
Page reads are combinational. The bench therefore sets the port and select on a falling edge and samples `pg_rdata` shortly after, with no clock edge in between. A page write takes effect on the next rising edge, so a read placed on the following falling edge already sees it.

Address and size results pass through one register. Each request is driven on a falling edge and withdrawn on the next one. The outputs are checked at that second falling edge, which lies half a cycle after the capturing rising edge. At the falling edge after that, `out_valid` is checked low again while `out_addr` is checked unchanged.

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen #(
  parameter bit WIDE16   = 1'b0,
  parameter bit HPAGE_EN = 1'b1,
  parameter int OFS_W    = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_wr,
  input  logic             pg_hi,
  input  logic [2:0]       pg_port,
  input  logic [7:0]       pg_wdata,
  output logic [7:0]       pg_rdata,
  input  logic             req_valid,
  input  logic [1:0]       req_chan,
  input  logic [15:0]      req_base,
  input  logic [15:0]      req_count,
  input  logic             req_dec,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [OFS_W-1:0] req_len,
  output logic             out_valid,
  output logic [30:0]      out_addr,
  output logic [17:0]      out_size
);
  localparam int NCH    = 4;
  localparam int AW     = 31;
  localparam int SIZE_W = 18;

  logic       port_ok;
  logic [1:0] port_ch;

  always_comb begin
    port_ok = 1'b1;
    port_ch = 2'd0;
    case (pg_port)
      3'd1:    port_ch = 2'd2;
      3'd2:    port_ch = 2'd3;
      3'd3:    port_ch = 2'd1;
      3'd7:    port_ch = 2'd0;
      default: port_ok = 1'b0;
    endcase
  end

  logic [7:0] lo_pg [NCH];
  logic [7:0] hi_pg [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) lo_pg[i] <= '0;
    end else if (pg_wr && port_ok && !pg_hi) begin
      lo_pg[port_ch] <= pg_wdata;
    end
  end

  generate
    if (HPAGE_EN) begin : g_hi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < NCH; i++) hi_pg[i] <= '0;
        end else if (pg_wr && port_ok && pg_hi) begin
          hi_pg[port_ch] <= pg_wdata;
        end
      end
    end else begin : g_no_hi
      always_comb begin
        for (int i = 0; i < NCH; i++) hi_pg[i] = '0;
      end
    end
  endgenerate

  assign pg_rdata = !port_ok ? 8'd0 : (pg_hi ? hi_pg[port_ch] : lo_pg[port_ch]);

  logic [AW-1:0]     cur_addr, phys_base, ofs_w, len_w, nxt_addr;
  logic [SIZE_W-1:0] nxt_size;

  assign cur_addr  = AW'(req_base) << WIDE16;
  assign phys_base = {hi_pg[req_chan][6:0], 24'd0} | {7'd0, lo_pg[req_chan], 16'd0} | cur_addr;
  assign ofs_w     = AW'(req_offset);
  assign len_w     = AW'(req_len);
  assign nxt_addr  = req_dec ? (phys_base - ofs_w - len_w) : (phys_base + ofs_w);
  assign nxt_size  = (SIZE_W'(req_count) + SIZE_W'(1)) << WIDE16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_size  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr <= nxt_addr;
        out_size <= nxt_size;
      end
    end
  end
endmodule

module dma_page_addr_gen_chk #(
  parameter bit HPAGE_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pg_hi,
  input logic [2:0]  pg_port,
  input logic [7:0]  pg_rdata,
  input logic        req_valid,
  input logic        out_valid,
  input logic [30:0] out_addr,
  input logic [17:0] out_size
);
  logic bad_port;
  assign bad_port = (pg_port == 3'd0) || (pg_port == 3'd4) || (pg_port == 3'd5) || (pg_port == 3'd6);

  AST_RESULT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> out_valid); // R10
  AST_NO_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !out_valid); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> ($stable(out_addr) && $stable(out_size))); // R10
  AST_BAD_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bad_port |-> (pg_rdata == 8'd0)); // R2
  AST_HI_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (!HPAGE_EN && pg_hi) |-> (pg_rdata == 8'd0)); // R4
  AST_SIZE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_size != 18'd0)); // R9
endmodule

bind dma_page_addr_gen dma_page_addr_gen_chk #(.HPAGE_EN(HPAGE_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_hi(pg_hi), .pg_port(pg_port), .pg_rdata(pg_rdata),
  .req_valid(req_valid), .out_valid(out_valid), .out_addr(out_addr), .out_size(out_size)
);

// File: tb/dma_page_addr_gen_bench.sv
`timescale 1ns/1ps
module dma_page_addr_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic        a_wr = 0, a_hi = 0, a_rv = 0, a_dec = 0;
  logic [2:0]  a_port = 0;
  logic [7:0]  a_wd = 0, a_rd;
  logic [1:0]  a_ch = 0;
  logic [15:0] a_base = 0, a_cnt = 0;
  logic [16:0] a_ofs = 0, a_len = 0;
  logic        a_ov;
  logic [30:0] a_addr;
  logic [17:0] a_size;

  logic        b_wr = 0, b_hi = 0, b_rv = 0, b_dec = 0;
  logic [2:0]  b_port = 0;
  logic [7:0]  b_wd = 0, b_rd;
  logic [1:0]  b_ch = 0;
  logic [15:0] b_base = 0, b_cnt = 0;
  logic [16:0] b_ofs = 0, b_len = 0;
  logic        b_ov;
  logic [30:0] b_addr;
  logic [17:0] b_size;

  dma_page_addr_gen #(.WIDE16(1'b0), .HPAGE_EN(1'b1), .OFS_W(17)) u_dma_page_addr_gen (
    .clk(clk), .rst_n(rst_n), .pg_wr(a_wr), .pg_hi(a_hi), .pg_port(a_port), .pg_wdata(a_wd),
    .pg_rdata(a_rd), .req_valid(a_rv), .req_chan(a_ch), .req_base(a_base), .req_count(a_cnt),
    .req_dec(a_dec), .req_offset(a_ofs), .req_len(a_len), .out_valid(a_ov), .out_addr(a_addr),
    .out_size(a_size));

  dma_page_addr_gen #(.WIDE16(1'b1), .HPAGE_EN(1'b0), .OFS_W(17)) u_dma_page_addr_gen_w16 (
    .clk(clk), .rst_n(rst_n), .pg_wr(b_wr), .pg_hi(b_hi), .pg_port(b_port), .pg_wdata(b_wd),
    .pg_rdata(b_rd), .req_valid(b_rv), .req_chan(b_ch), .req_base(b_base), .req_count(b_cnt),
    .req_dec(b_dec), .req_offset(b_ofs), .req_len(b_len), .out_valid(b_ov), .out_addr(b_addr),
    .out_size(b_size));

  localparam int NV = 6;
  localparam logic [1:0]  V_CH   [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
  localparam logic [15:0] V_BASE [NV] = '{16'h1000, 16'hABCD, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0100};
  localparam logic        V_DEC  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [16:0] V_OFS  [NV] = '{17'h10, 17'h5, 17'h1, 17'h0, 17'h1, 17'h100};
  localparam logic [16:0] V_LEN  [NV] = '{17'h20, 17'h10, 17'h1, 17'h1, 17'h0, 17'h0};
  localparam logic [15:0] V_CNT  [NV] = '{16'h00FF, 16'h0000, 16'hFFFF, 16'h0003, 16'h0001, 16'h0007};
  localparam logic [30:0] V_ADDR [NV] = '{31'h0512_1010, 31'h0134_ABB8, 31'h0000_0000,
                                          31'h7FFF_FFFF, 31'h0513_0000, 31'h0134_0000};
  localparam logic [17:0] V_SIZE [NV] = '{18'h100, 18'h1, 18'h10000, 18'h4, 18'h2, 18'h8};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_write(input logic [2:0] port, input logic hi, input logic [7:0] d);
    @(negedge clk); a_port = port; a_hi = hi; a_wd = d; a_wr = 1'b1;
    @(negedge clk); a_wr = 1'b0;
  endtask

  task automatic a_read(input string req, input logic [2:0] port, input logic hi, input logic [7:0] exp);
    @(negedge clk); a_port = port; a_hi = hi;
    #0.5 chk(req, {24'd0, a_rd}, {24'd0, exp});
  endtask

  task automatic b_write(input logic [2:0] port, input logic hi, input logic [7:0] d);
    @(negedge clk); b_port = port; b_hi = hi; b_wd = d; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", {31'd0, a_ov}, 32'd0);
    chk("R11 out_addr", {1'b0, a_addr}, 32'd0);
    chk("R11 out_size", {14'd0, a_size}, 32'd0);
    rst_n = 1'b1;
    a_read("R11 lo page", 3'd7, 1'b0, 8'h00);
    a_read("R11 hi page", 3'd1, 1'b1, 8'h00);

    // R1 and R3: page writes through the sparse map
    a_write(3'd7, 1'b0, 8'h12); a_write(3'd7, 1'b1, 8'h85);
    a_write(3'd3, 1'b0, 8'h34); a_write(3'd3, 1'b1, 8'h01);
    a_write(3'd1, 1'b0, 8'hFF); a_write(3'd1, 1'b1, 8'h7F);
    a_write(3'd2, 1'b0, 8'h00); a_write(3'd2, 1'b1, 8'h00);
    a_read("R1 port7 lo", 3'd7, 1'b0, 8'h12);
    a_read("R1 port3 lo", 3'd3, 1'b0, 8'h34);
    a_read("R1 port1 lo", 3'd1, 1'b0, 8'hFF);
    a_read("R3 port7 hi", 3'd7, 1'b1, 8'h85);
    a_read("R3 port3 hi", 3'd3, 1'b1, 8'h01);
    a_read("R3 port1 hi", 3'd1, 1'b1, 8'h7F);

    // R2: invalid ports drop writes and read zero
    for (int p = 0; p < 8; p++) begin
      if (p == 0 || p == 4 || p == 5 || p == 6) begin
        a_write(3'(p), 1'b0, 8'hA5);
        a_write(3'(p), 1'b1, 8'h5A);
        a_read("R2 bad port lo", 3'(p), 1'b0, 8'h00);
        a_read("R2 bad port hi", 3'(p), 1'b1, 8'h00);
      end
    end
    a_read("R2 port7 lo kept", 3'd7, 1'b0, 8'h12);
    a_read("R2 port2 lo kept", 3'd2, 1'b0, 8'h00);
    a_read("R2 port2 hi kept", 3'd2, 1'b1, 8'h00);

    // R5 R6 R7 R9 R10: vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      a_ch = V_CH[v]; a_base = V_BASE[v]; a_dec = V_DEC[v];
      a_ofs = V_OFS[v]; a_len = V_LEN[v]; a_cnt = V_CNT[v]; a_rv = 1'b1;
      @(negedge clk); a_rv = 1'b0;
      chk(V_DEC[v] ? "R7 R5 addr dec" : "R6 R5 addr inc", {1'b0, a_addr}, {1'b0, V_ADDR[v]});
      chk("R9 size", {14'd0, a_size}, {14'd0, V_SIZE[v]});
      chk("R10 valid high", {31'd0, a_ov}, 32'd1);
      a_base = 16'h4444; a_ch = 2'd3;
      @(negedge clk);
      chk("R10 valid low", {31'd0, a_ov}, 32'd0);
      chk("R10 addr held", {1'b0, a_addr}, {1'b0, V_ADDR[v]});
    end

    // R8 R4: word-wide controller without high page
    b_write(3'd7, 1'b0, 8'h20);
    b_write(3'd7, 1'b1, 8'h55);
    @(negedge clk); b_port = 3'd7; b_hi = 1'b1;
    #0.5 chk("R4 hi reads zero", {24'd0, b_rd}, 32'd0);
    b_hi = 1'b0;
    #0.5 chk("R1 w16 lo page", {24'd0, b_rd}, 32'h20);
    @(negedge clk);
    b_ch = 2'd0; b_base = 16'h8001; b_dec = 1'b0; b_ofs = 17'd2; b_len = 17'd4; b_cnt = 16'd9; b_rv = 1'b1;
    @(negedge clk); b_rv = 1'b0;
    chk("R8 R4 w16 inc addr", {1'b0, b_addr}, 32'h0021_0004);
    chk("R9 w16 size", {14'd0, b_size}, 32'd20);
    @(negedge clk);
    b_base = 16'h0010; b_dec = 1'b1; b_rv = 1'b1;
    @(negedge clk); b_rv = 1'b0;
    chk("R8 R7 w16 dec addr", {1'b0, b_addr}, 32'h0020_001A);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule